// File: doc/BRIEF.md
# Segment-Status Address Space Extender

This block sits between a 20-bit segmented-CPU bus and a physical memory four times larger. Each memory cycle on that bus carries a two-bit status code naming the segment register (code, data, extra or stack) that formed the address. The extender captures this code with the address when a bus cycle begins. It then puts two extra high bits in front of the 20-bit address to form a 22-bit physical address. That address stays fixed until the next bus cycle begins.

A small mode register picks how the status code is used. In plain mode the upper bits are always zero, so the system behaves as an ordinary 1 MB machine. In extra-segment mode only accesses made through the extra segment go to the second megabyte. In split mode each segment gets its own megabyte, which yields separate code, stack and data spaces. A segment override prefix changes the status the CPU reports, so an overridden access lands in the overriding segment's region without any extra work. I/O and interrupt-acknowledge cycles always stay in the first megabyte.

The cycle-start strobe acts as a valid with no ready. The block can take a new bus cycle on every clock, so it never applies back-pressure. The mode register is a plain control port.

Top module: `ssx_addr_extender`

## Requirements
- R1: After reset `phys_addr_o` is 0 and the mode is plain (code 00).
- R2: When `cyc_start_i` is high at a rising edge, address, status and memory flag are captured at that edge. The new `phys_addr_o` is visible after that edge and holds, whatever the inputs do, until the next capturing edge.
- R3: In plain mode (code 00), bits 21:20 of the output are 0.
- R4: In split mode (code 10), for a memory cycle, bits 21:20 equal the captured status code (00 extra, 01 stack, 10 code or none, 11 data).
- R5: In extra-segment mode (code 01), for a memory cycle, bit 20 is 1 exactly when the status is 00 and bit 21 is 0.
- R6: For a non-memory cycle (`mem_cycle_i` low), bits 21:20 are 0 in every mode.
- R7: A mode write of 00, 01 or 10 takes effect at its rising edge. A write of 11 is ignored and the previous mode stays.
- R8: Bits 19:0 of the output always equal the captured bus address.
- R9: A bus cycle that starts on the same edge as a mode write is mapped with the mode that was in force before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cyc_start_i | input | 1 | Bus cycle start strobe (valid, no ready) |
| mem_cycle_i | input | 1 | 1 for a memory cycle, 0 for I/O or interrupt acknowledge |
| seg_stat_i | input | 2 | Segment status code of the access |
| bus_addr_i | input | 20 | Bus address |
| mode_we_i | input | 1 | Mode register write enable |
| mode_wdata_i | input | 2 | Mode value: 00 plain, 01 extra-segment, 10 split |
| phys_addr_o | output | 22 | Extended physical address |

## Verification
Every mapped address appears one edge after the strobe that captures it. The bench raises the strobe at a falling edge and reads the output at the next falling edge. It then scrambles the inputs and reads again one cycle later to confirm the hold. A mode write lands at the same edge it is presented on, so the bench's shadow of the mode changes only after that edge. The case where a write and a strobe coincide is checked against the old mode.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  typedef enum logic [1:0] {
    MAP_OFF     = 2'b00,
    MAP_ES_ONLY = 2'b01,
    MAP_FULL    = 2'b10
  } map_mode_e;

  localparam logic [1:0] SEG_ES = 2'b00;
  localparam logic [1:0] SEG_SS = 2'b01;
  localparam logic [1:0] SEG_CS = 2'b10;
  localparam logic [1:0] SEG_DS = 2'b11;

  localparam int unsigned SEG_W = 2;

  function automatic logic mode_code_ok(input logic [1:0] code);
    return (code != 2'b11);
  endfunction
endpackage

// File: rtl/ssx_mode_reg.sv
module ssx_mode_reg
  import ssx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  output map_mode_e  mode_o
);
  map_mode_e mode_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q <= MAP_OFF;
    end else if (we_i && mode_code_ok(wdata_i)) begin
      mode_q <= map_mode_e'(wdata_i);
    end
  end

  assign mode_o = mode_q;

  // R7: a reserved code leaves the mode untouched
  assert_reserved_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i == 2'b11) |=> $stable(mode_q));

  // R7: a legal code is taken
  assert_legal_taken_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i != 2'b11) |=> (mode_q == $past(wdata_i)));
endmodule

// File: rtl/ssx_bank_map.sv
module ssx_bank_map
  import ssx_pkg::*;
#(
  parameter int unsigned LOW_W  = 20,
  localparam int unsigned PHYS_W = LOW_W + SEG_W
) (
  input  map_mode_e          mode_i,
  input  logic [SEG_W-1:0]   seg_i,
  input  logic               is_mem_i,
  input  logic [LOW_W-1:0]   addr_i,
  output logic [PHYS_W-1:0]  phys_o
);
  logic [SEG_W-1:0] region;

  always_comb begin
    region = '0;
    if (is_mem_i) begin
      unique case (mode_i)
        MAP_FULL:    region = seg_i;
        MAP_ES_ONLY: region = {1'b0, (seg_i == SEG_ES)};
        default:     region = '0;
      endcase
    end
  end

  assign phys_o = {region, addr_i};
endmodule

// File: rtl/ssx_cycle_latch.sv
module ssx_cycle_latch #(
  parameter int unsigned W = 22
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic         past_ok;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      q       <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (load_i) q <= d_i;
    end
  end

  assign q_o = q;

  // R2: no strobe, no change
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(load_i)) |-> $stable(q));
endmodule

// File: rtl/ssx_addr_extender.sv
module ssx_addr_extender
  import ssx_pkg::*;
#(
  parameter int unsigned LOW_W  = 20,
  localparam int unsigned PHYS_W = LOW_W + SEG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_start_i,
  input  logic              mem_cycle_i,
  input  logic [SEG_W-1:0]  seg_stat_i,
  input  logic [LOW_W-1:0]  bus_addr_i,
  input  logic              mode_we_i,
  input  logic [1:0]        mode_wdata_i,
  output logic [PHYS_W-1:0] phys_addr_o
);
  map_mode_e         mode;
  logic [PHYS_W-1:0] mapped;

  ssx_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we_i),
    .wdata_i (mode_wdata_i),
    .mode_o  (mode)
  );

  ssx_bank_map #(.LOW_W(LOW_W)) u_map (
    .mode_i   (mode),
    .seg_i    (seg_stat_i),
    .is_mem_i (mem_cycle_i),
    .addr_i   (bus_addr_i),
    .phys_o   (mapped)
  );

  ssx_cycle_latch #(.W(PHYS_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cyc_start_i),
    .d_i    (mapped),
    .q_o    (phys_addr_o)
  );

  // R8: low bits follow the captured bus address
  assert_low_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_i |=> (phys_addr_o[LOW_W-1:0] == $past(bus_addr_i)));

  // R4: split mode region equals status code
  assert_full_region_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && mem_cycle_i && mode == MAP_FULL)
      |=> (phys_addr_o[PHYS_W-1:LOW_W] == $past(seg_stat_i)));

  // R5: extra-segment mode never touches the upper half
  assert_es_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && mode == MAP_ES_ONLY)
      |=> (phys_addr_o[PHYS_W-1] == 1'b0));

  // R6: non-memory cycles stay low
  assert_io_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && !mem_cycle_i) |=> (phys_addr_o[PHYS_W-1:LOW_W] == '0));

  // R3: plain mode stays low
  assert_plain_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && mode == MAP_OFF) |=> (phys_addr_o[PHYS_W-1:LOW_W] == '0));
endmodule

// File: tb/ssx_addr_extender_bench.sv
module ssx_addr_extender_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mem = 1'b0;
  logic [1:0]  seg = 2'b00;
  logic [19:0] addr = '0;
  logic        mwe = 1'b0;
  logic [1:0]  mwd = 2'b00;
  logic [21:0] phys;

  int errors = 0;
  int checks = 0;
  logic [1:0] mode_sh = 2'b00;

  always #2 clk = ~clk;

  ssx_addr_extender u_ssx_addr_extender (
    .clk_i (clk), .rst_ni (rst_n), .cyc_start_i (start), .mem_cycle_i (mem),
    .seg_stat_i (seg), .bus_addr_i (addr), .mode_we_i (mwe),
    .mode_wdata_i (mwd), .phys_addr_o (phys)
  );

  function automatic logic [21:0] expect_phys(input logic [1:0] m, input logic [1:0] s,
                                               input logic is_mem, input logic [19:0] a);
    logic [1:0] hi;
    hi = 2'b00;
    if (is_mem && m == 2'b10) hi = s;
    if (is_mem && m == 2'b01) hi = {1'b0, s == 2'b00};
    return {hi, a};
  endfunction

  task automatic check(input logic [21:0] act, input logic [21:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] v);
    @(negedge clk);
    mwe = 1'b1; mwd = v;
    @(negedge clk);
    mwe = 1'b0;
    if (v != 2'b11) mode_sh = v;
  endtask

  task automatic bus_cycle(input logic [1:0] s, input logic is_mem, input logic [19:0] a,
                           input string req);
    logic [21:0] exp;
    @(negedge clk);
    start = 1'b1; seg = s; mem = is_mem; addr = a;
    exp = expect_phys(mode_sh, s, is_mem, a);
    @(negedge clk);
    start = 1'b0;
    check(phys, exp, req);
    seg = 2'($urandom); mem = 1'($urandom); addr = 20'($urandom);
    @(negedge clk);
    check(phys, exp, "R2 hold");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [21:0] exp;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(phys, 22'h0, "R1 reset output");
    // R1/R3: default plain mode
    bus_cycle(2'b00, 1'b1, 20'hFFFFF, "R1 R3 plain default");
    bus_cycle(2'b11, 1'b1, 20'h12345, "R3 plain DS");
    // R7: reserved code ignored
    write_mode(2'b11);
    bus_cycle(2'b00, 1'b1, 20'hABCDE, "R7 reserved ignored");
    // R5: extra-segment mode
    write_mode(2'b01);
    bus_cycle(2'b00, 1'b1, 20'h00010, "R5 ES to 2nd MB");
    bus_cycle(2'b01, 1'b1, 20'h00020, "R5 SS stays");
    bus_cycle(2'b10, 1'b1, 20'h00030, "R5 CS stays");
    bus_cycle(2'b11, 1'b1, 20'h00040, "R5 DS stays");
    bus_cycle(2'b00, 1'b0, 20'h00060, "R6 IO in ES mode");
    write_mode(2'b11);
    bus_cycle(2'b00, 1'b1, 20'h00070, "R7 reserved keeps ES mode");
    // R4: split mode
    write_mode(2'b10);
    bus_cycle(2'b00, 1'b1, 20'hFFFF0, "R4 ES region");
    bus_cycle(2'b01, 1'b1, 20'h11111, "R4 SS region");
    bus_cycle(2'b10, 1'b1, 20'h22222, "R4 CS region");
    bus_cycle(2'b11, 1'b1, 20'hFFFFF, "R4 R8 DS region");
    bus_cycle(2'b11, 1'b0, 20'h003F8, "R6 IO in split mode");
    // R9: strobe coinciding with a mode write uses the old mode
    write_mode(2'b01);
    @(negedge clk);
    start = 1'b1; seg = 2'b11; mem = 1'b1; addr = 20'h55555;
    mwe = 1'b1; mwd = 2'b10;
    exp = expect_phys(2'b01, 2'b11, 1'b1, 20'h55555);
    @(negedge clk);
    start = 1'b0; mwe = 1'b0; mode_sh = 2'b10;
    check(phys, exp, "R9 old mode used");
    bus_cycle(2'b11, 1'b1, 20'h55555, "R9 new mode after");
    write_mode(2'b00);
    bus_cycle(2'b10, 1'b1, 20'h0BEEF, "R3 back to plain");
    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) write_mode(2'($urandom));
      bus_cycle(2'($urandom), 1'($urandom_range(0, 4) != 0), 20'($urandom), "R4 R5 R6 R8 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule